// File: doc/BRIEF.md
# Sprite Attribute Memory Write Port

This block is the processor-facing write path into a 544-byte sprite attribute store. The store is split into a 512-byte main table, kept as 256 sixteen-bit words, and a 32-byte auxiliary table. The processor loads a 9-bit word address and then sends a stream of byte writes. A byte-phase flag decides where each byte goes.

When the address points into the main table, the first byte of a pair is held in a staging register. The second byte commits both bytes as one word. A half-written word is therefore never visible. When address bit 8 is set, each byte goes straight into the auxiliary table. The word address moves forward after every completed pair.

When rotation is enabled, a first-sprite index follows the word address so that priority can rotate with it. A one-cycle changed pulse marks writes that really alter stored contents. Each auxiliary byte holds two bits for each of four sprites: an X high bit and a size bit. A decode port returns them for any sprite. A combinational byte read port exposes the whole store.

Top module: `sam_write_port`

## Requirements
- R1: After reset, the word address, byte phase, first-sprite index and changed flag are 0, and all 544 stored bytes read as 0.
- R2: A cycle with addr_load_i high sets the word address to addr_i and clears the byte phase. A byte write strobed in that same cycle is discarded and changes no stored byte.
- R3: A byte written while address bit 8 is 0 and the phase is 0 changes no stored byte. It is latched, the phase becomes 1 and the address holds.
- R4: A byte written while address bit 8 is 0 and the phase is 1 stores the latched byte at byte index 2*addr and the incoming byte at 2*addr+1, both in the same cycle. The phase then returns to 0 and the address increments.
- R5: A byte written while address bit 8 is 1 goes to byte index 512 + 2*addr[3:0] + phase. Address bits 7:4 are ignored. The phase toggles, and the address increments only on the write made with phase 1.
- R6: The word address is 9 bits and wraps from 0x1FF to 0x000 on increment.
- R7: With rot_en_i high, every address increment sets the first-sprite index to bits 7:1 of the new address. With rot_en_i low, the index holds its value.
- R8: changed_o is high for exactly the one cycle after a write edge that stored at least one byte differing from its previous value. Staging writes and identical rewrites leave it low.
- R9: For sprite n, spr_xhi_o is bit 2*(n mod 4) and spr_big_o is bit 2*(n mod 4)+1 of auxiliary byte n div 4, which is byte index 512 + n div 4.
- R10: dbg_data_o returns the stored byte at index dbg_idx_i combinationally. Indices 0 to 511 select the main table: even is the low byte of word idx/2, odd is the high byte. Indices 512 to 543 select the auxiliary table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_load_i | input | 1 | Load word address and clear phase |
| addr_i | input | 9 | Word address to load |
| rot_en_i | input | 1 | Priority rotation enable |
| wr_en_i | input | 1 | Single-cycle byte write strobe |
| wr_data_i | input | 8 | Byte to write |
| word_addr_o | output | 9 | Current word address |
| phase_o | output | 1 | Current byte phase |
| first_spr_o | output | 7 | First-sprite index for priority rotation |
| changed_o | output | 1 | Stored contents altered by last write |
| dbg_idx_i | input | 10 | Byte index for debug read |
| dbg_data_o | output | 8 | Byte at dbg_idx_i |
| spr_sel_i | input | 7 | Sprite number for auxiliary field decode |
| spr_xhi_o | output | 1 | X high bit of selected sprite |
| spr_big_o | output | 1 | Size bit of selected sprite |

## Verification
The assertions check the following on every cycle: the phase and address moves for each write kind, the wrap at 0x1FF, the effect of an address load, first-index tracking, that a committed word lands at its index, and that the changed flag only follows a write. Where the auxiliary bytes land, including aliasing through the ignored address bits, the exact contents of the whole store, and the sprite field decode are shown only by the bench. It streams bytes through the complete address space, dumps every byte and decodes all 128 sprites against an arithmetic model. The same applies to a write discarded by a concurrent load and to identical rewrites that must not raise the changed flag.

// File: rtl/sam_pkg.sv
package sam_pkg;
  typedef enum logic [1:0] {
    OP_IDLE,
    OP_STAGE,
    OP_COMMIT,
    OP_AUX
  } sam_op_e;
endpackage

// File: rtl/sam_addr_ctl.sv
module sam_addr_ctl
  import sam_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int AX_W   = 5,
  localparam int FS_W  = ADDR_W - 2,
  localparam int MW_W  = ADDR_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              rot_en_i,
  input  logic              wr_en_i,
  input  logic [7:0]        wr_data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              phase_o,
  output logic [FS_W-1:0]   first_o,
  output logic              main_we_o,
  output logic [MW_W-1:0]   main_widx_o,
  output logic [15:0]       main_wdata_o,
  output logic              aux_we_o,
  output logic [AX_W-1:0]   aux_idx_o,
  output logic [7:0]        aux_wdata_o
);
  logic [ADDR_W-1:0] addr_q, addr_nx;
  logic              phase_q;
  logic [7:0]        stage_q;
  logic [FS_W-1:0]   first_q;
  sam_op_e           op;
  logic              inc;

  always_comb begin
    op = OP_IDLE;
    if (!load_i && wr_en_i) begin
      if (addr_q[ADDR_W-1])  op = OP_AUX;
      else if (!phase_q)     op = OP_STAGE;
      else                   op = OP_COMMIT;
    end
  end

  assign inc     = (op == OP_COMMIT) || (op == OP_AUX && phase_q);
  assign addr_nx = addr_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      phase_q <= 1'b0;
      stage_q <= '0;
      first_q <= '0;
    end else begin
      if (load_i) begin
        addr_q  <= load_val_i;
        phase_q <= 1'b0;
      end else begin
        unique case (op)
          OP_STAGE: begin
            stage_q <= wr_data_i;
            phase_q <= 1'b1;
          end
          OP_COMMIT: begin
            phase_q <= 1'b0;
            addr_q  <= addr_nx;
          end
          OP_AUX: begin
            phase_q <= ~phase_q;
            if (phase_q) addr_q <= addr_nx;
          end
          default: ;
        endcase
      end
      if (inc && rot_en_i) first_q <= addr_nx[ADDR_W-2:1];
    end
  end

  assign addr_o       = addr_q;
  assign phase_o      = phase_q;
  assign first_o      = first_q;
  assign main_we_o    = (op == OP_COMMIT);
  assign main_widx_o  = addr_q[MW_W-1:0];
  assign main_wdata_o = {wr_data_i, stage_q};
  assign aux_we_o     = (op == OP_AUX);
  assign aux_idx_o    = {addr_q[AX_W-2:0], phase_q};
  assign aux_wdata_o  = wr_data_i;

  AST_LOAD_CLEARS_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(load_i) |-> (!phase_q && addr_q == $past(load_val_i))); // R2
  AST_STAGE_HOLDS_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(op == OP_STAGE) |-> (phase_q && addr_q == $past(addr_q))); // R3
  AST_COMMIT_ADVANCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(op == OP_COMMIT) |-> (!phase_q && addr_q == $past(addr_q) + 1'b1)); // R4
  AST_AUX_TOGGLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(op == OP_AUX) |-> (phase_q != $past(phase_q))); // R5
  AST_ADDR_WRAPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(inc) && $past(addr_q) == '1) |-> (addr_q == '0)); // R6
  AST_ROT_TRACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(inc && rot_en_i) |-> (first_q == addr_q[ADDR_W-2:1])); // R7
  AST_ROT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!rot_en_i) |-> $stable(first_q)); // R7
endmodule

// File: rtl/sam_store.sv
module sam_store #(
  parameter int MAIN_WORDS = 256,
  parameter int AUX_BYTES  = 32,
  localparam int MW_W  = $clog2(MAIN_WORDS),
  localparam int AX_W  = $clog2(AUX_BYTES),
  localparam int IDX_W = $clog2(2 * MAIN_WORDS + AUX_BYTES),
  localparam int SPR_W = AX_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             main_we_i,
  input  logic [MW_W-1:0]  main_widx_i,
  input  logic [15:0]      main_wdata_i,
  input  logic             aux_we_i,
  input  logic [AX_W-1:0]  aux_idx_i,
  input  logic [7:0]       aux_wdata_i,
  input  logic [IDX_W-1:0] dbg_idx_i,
  output logic [7:0]       dbg_data_o,
  input  logic [SPR_W-1:0] spr_sel_i,
  output logic             spr_xhi_o,
  output logic             spr_big_o,
  output logic             changed_o
);
  localparam logic [IDX_W-1:0] MAIN_LIM = IDX_W'(2 * MAIN_WORDS);
  localparam logic [IDX_W-1:0] TOT_LIM  = IDX_W'(2 * MAIN_WORDS + AUX_BYTES);

  logic [15:0] main_q [MAIN_WORDS];
  logic [7:0]  aux_q  [AUX_BYTES];
  logic        chg_q;
  logic        main_diff, aux_diff;

  assign main_diff = main_q[main_widx_i] != main_wdata_i;
  assign aux_diff  = aux_q[aux_idx_i] != aux_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < MAIN_WORDS; i++) main_q[i] <= '0;
      for (int i = 0; i < AUX_BYTES; i++)  aux_q[i]  <= '0;
      chg_q <= 1'b0;
    end else begin
      if (main_we_i) main_q[main_widx_i] <= main_wdata_i;
      if (aux_we_i)  aux_q[aux_idx_i]    <= aux_wdata_i;
      chg_q <= (main_we_i && main_diff) || (aux_we_i && aux_diff);
    end
  end

  logic [15:0] rd_word;
  always_comb begin
    rd_word    = main_q[dbg_idx_i[MW_W:1]];
    dbg_data_o = '0;
    if (dbg_idx_i < MAIN_LIM)
      dbg_data_o = dbg_idx_i[0] ? rd_word[15:8] : rd_word[7:0];
    else if (dbg_idx_i < TOT_LIM)
      dbg_data_o = aux_q[dbg_idx_i[AX_W-1:0]];
  end

  // two bits per sprite, four sprites per auxiliary byte
  logic [7:0] spr_byte;
  assign spr_byte  = aux_q[spr_sel_i[SPR_W-1:2]];
  assign spr_xhi_o = spr_byte[{spr_sel_i[1:0], 1'b0}];
  assign spr_big_o = spr_byte[{spr_sel_i[1:0], 1'b1}];

  assign changed_o = chg_q;

  AST_ONE_TABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(main_we_i && aux_we_i)); // R5
  AST_WORD_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(main_we_i) |-> (main_q[$past(main_widx_i)] == $past(main_wdata_i))); // R4
  AST_CHANGE_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    changed_o |-> $past(main_we_i || aux_we_i)); // R8
endmodule

// File: rtl/sam_write_port.sv
module sam_write_port #(
  parameter int MAIN_BYTES = 512,
  parameter int AUX_BYTES  = 32,
  localparam int MAIN_WORDS = MAIN_BYTES / 2,
  localparam int MW_W   = $clog2(MAIN_WORDS),
  localparam int ADDR_W = MW_W + 1,
  localparam int AX_W   = $clog2(AUX_BYTES),
  localparam int IDX_W  = $clog2(MAIN_BYTES + AUX_BYTES),
  localparam int SPR_W  = AX_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rot_en_i,
  input  logic              wr_en_i,
  input  logic [7:0]        wr_data_i,
  output logic [ADDR_W-1:0] word_addr_o,
  output logic              phase_o,
  output logic [ADDR_W-3:0] first_spr_o,
  output logic              changed_o,
  input  logic [IDX_W-1:0]  dbg_idx_i,
  output logic [7:0]        dbg_data_o,
  input  logic [SPR_W-1:0]  spr_sel_i,
  output logic              spr_xhi_o,
  output logic              spr_big_o
);
  logic            main_we, aux_we;
  logic [MW_W-1:0] main_widx;
  logic [15:0]     main_wdata;
  logic [AX_W-1:0] aux_idx;
  logic [7:0]      aux_wdata;

  sam_addr_ctl #(.ADDR_W(ADDR_W), .AX_W(AX_W)) u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (addr_load_i),
    .load_val_i  (addr_i),
    .rot_en_i    (rot_en_i),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .addr_o      (word_addr_o),
    .phase_o     (phase_o),
    .first_o     (first_spr_o),
    .main_we_o   (main_we),
    .main_widx_o (main_widx),
    .main_wdata_o(main_wdata),
    .aux_we_o    (aux_we),
    .aux_idx_o   (aux_idx),
    .aux_wdata_o (aux_wdata)
  );

  sam_store #(.MAIN_WORDS(MAIN_WORDS), .AUX_BYTES(AUX_BYTES)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .main_we_i   (main_we),
    .main_widx_i (main_widx),
    .main_wdata_i(main_wdata),
    .aux_we_i    (aux_we),
    .aux_idx_i   (aux_idx),
    .aux_wdata_i (aux_wdata),
    .dbg_idx_i   (dbg_idx_i),
    .dbg_data_o  (dbg_data_o),
    .spr_sel_i   (spr_sel_i),
    .spr_xhi_o   (spr_xhi_o),
    .spr_big_o   (spr_big_o),
    .changed_o   (changed_o)
  );
endmodule

// File: tb/sam_write_port_bench.sv
module sam_write_port_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       addr_load_i = 1'b0;
  logic [8:0] addr_i = '0;
  logic       rot_en_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic [8:0] word_addr_o;
  logic       phase_o;
  logic [6:0] first_spr_o;
  logic       changed_o;
  logic [9:0] dbg_idx_i = '0;
  logic [7:0] dbg_data_o;
  logic [6:0] spr_sel_i = '0;
  logic       spr_xhi_o, spr_big_o;

  sam_write_port u_sam_write_port (.*);

  always #10 clk_i = ~clk_i;

  int errors = 0, checks = 0;
  bit done = 0;
  int exp_mem [544];
  int m_addr = 0, m_phase = 0, m_stage = 0, m_first = 0, m_chg = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_regs(input string req);
    chk(word_addr_o == 9'(m_addr), {req, " addr"}, word_addr_o, m_addr);
    chk(phase_o == 1'(m_phase), {req, " phase"}, phase_o, m_phase);
    chk(first_spr_o == 7'(m_first), {req, " R7 first"}, first_spr_o, m_first);
    chk(changed_o == 1'(m_chg), {req, " R8 changed"}, changed_o, m_chg);
  endtask

  function automatic void model_inc(input bit rot);
    m_addr = (m_addr + 1) & 511;
    if (rot) m_first = (m_addr & 254) >> 1;
  endfunction

  task automatic put(input int b, input bit rot, input string req);
    int idx;
    wr_en_i = 1'b1; wr_data_i = 8'(b); rot_en_i = rot;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    m_chg = 0;
    if (m_addr >= 256) begin
      idx = 512 + (m_addr & 15) * 2 + m_phase;
      m_chg = (exp_mem[idx] != b);
      exp_mem[idx] = b;
      if (m_phase == 1) model_inc(rot);
      m_phase ^= 1;
    end else if (m_phase == 0) begin
      m_stage = b; m_phase = 1;
    end else begin
      m_chg = (exp_mem[2*m_addr] != m_stage) || (exp_mem[2*m_addr+1] != b);
      exp_mem[2*m_addr] = m_stage; exp_mem[2*m_addr+1] = b;
      m_phase = 0;
      model_inc(rot);
    end
    check_regs(req);
  endtask

  task automatic load(input int a, input bit with_wr, input int b);
    addr_load_i = 1'b1; addr_i = 9'(a); wr_en_i = with_wr; wr_data_i = 8'(b);
    @(negedge clk_i);
    addr_load_i = 1'b0; wr_en_i = 1'b0;
    m_addr = a; m_phase = 0; m_chg = 0;
    check_regs("R2 load");
  endtask

  task automatic dump(input string req);
    for (int i = 0; i < 544; i++) begin
      dbg_idx_i = 10'(i);
      #1;
      chk(dbg_data_o == 8'(exp_mem[i]), req, dbg_data_o, exp_mem[i]);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 544; i++) exp_mem[i] = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_regs("R1 reset");
    dump("R1 R10 reset contents");

    // R3 R4: stream the whole main table, rotation on
    load(0, 0, 0);
    for (int i = 0; i < 512; i++) put((i * 37 + 5) & 255, 1, "R3 R4 main stream");
    // R5: auxiliary stream, addresses 0x110..0x11F alias 0x100..0x10F
    for (int i = 0; i < 64; i++) put((i * 11 + 3) & 255, 1, "R5 aux stream");
    dump("R10 R4 R5 contents");

    // R6: wrap from 0x1FF
    load(511, 0, 0);
    put(8'hA5, 1, "R6 wrap lo");
    put(8'h5A, 1, "R6 wrap hi");
    chk(word_addr_o == 9'd0, "R6 wrapped addr", word_addr_o, 0);

    // R8: identical rewrite of word 5 does not pulse
    load(5, 0, 0);
    put(exp_mem[10], 1, "R8 same lo");
    put(exp_mem[11], 1, "R8 same hi");
    put(exp_mem[12] ^ 1, 1, "R8 diff lo");
    put(exp_mem[13], 1, "R8 diff hi");

    // R2: write coincident with load is dropped; load mid-pair clears phase
    load(40, 1, 8'hEE);
    put(8'h11, 1, "R2 stage");
    load(30, 0, 0);
    put(8'h22, 1, "R2 restage lo");
    put(8'h33, 1, "R2 restage hi");
    chk(exp_mem[60] == 8'h22, "R2 model lo", exp_mem[60], 8'h22);
    load(300, 1, 8'h77);
    dump("R2 R3 contents");

    // R7: rotation off holds first index
    load(100, 0, 0);
    for (int i = 0; i < 8; i++) put(i * 29, 0, "R7 rot off");
    put(1, 1, "R7 rot on lo");
    put(2, 1, "R7 rot on hi");

    // R9: sprite field decode over all sprites
    for (int n = 0; n < 128; n++) begin
      int b;
      spr_sel_i = 7'(n);
      #1;
      b = exp_mem[512 + n / 4];
      chk(spr_xhi_o == 1'((b >> (2 * (n % 4))) & 1), "R9 xhi", spr_xhi_o, (b >> (2 * (n % 4))) & 1);
      chk(spr_big_o == 1'((b >> (2 * (n % 4) + 1)) & 1), "R9 size", spr_big_o, (b >> (2 * (n % 4) + 1)) & 1);
    end
    dump("R10 final contents");
    finish_run();
  end
endmodule